// File: doc/BRIEF.md
# RTC calendar counter with alarm

This block keeps wall-clock time for a chip. A slow reference tick, nominally 32.768 kHz and presented as a one-cycle pulse in the system clock domain, feeds a programmable divider. With its reset divisor, the divider produces one seconds tick for every 32768 reference ticks. Each seconds tick advances a calendar held in two packed words. The date word holds the year, month and day. The time word holds the week of month, day of week, hour, minute and second. The calendar rolls over correctly across month ends and follows the Gregorian leap-year rule.

Two alarms compare against the calendar just after each update:

- A full alarm matches every field of both words.
- A daily alarm matches only the hour, minute and second.

A status register latches three events: the daily alarm, the seconds tick and the full alarm. Each event has its own enable, and the interrupt output is raised by any latched event whose enable is set.

Software uses a 32-bit register port with byte offsets:

| Offset | Register |
|---|---|
| 0x08 | status |
| 0x0C | divider (trim in bits 31:16, divisor in bits 15:0) |
| 0x10 | time word |
| 0x14 | date word |
| 0x18 | alarm time |
| 0x1C | alarm date |

The request side is a valid/ready channel. `req_ready` is always high, so the block never applies back-pressure, and a request is accepted on any clock edge where `req_valid` is high. A read returns its data one cycle later, marked by `rsp_valid`. The response has no ready signal, so the requester must take the response in the cycle it appears.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers hold the following values. Divider reads 0x00007FFF. Date reads year 2000, month 1, day 1. Time reads 00:00:00 with day of week 1 and week of month 1. Both alarm words read 0. Status reads 0, and `irq` is low.
- R2: With divisor N, a seconds tick occurs on the reference tick that finds the internal count at N, after which the count restarts at 0. This gives one seconds tick per N+1 reference ticks, so the reset divisor yields one tick per 32768. The trim field (bits 31:16) reads back exactly as written.
- R3: A write to the time or date word is visible on the next read. The write also restarts the divider count. A reference tick in the same cycle as the write produces no seconds tick, so the next seconds tick comes a full N+1 reference ticks later.
- R4: On each seconds tick the fields advance as follows. The second counts up and wraps from 59 to 0, carrying into the minute. The minute wraps from 59 to 0, carrying into the hour. The hour wraps from 23 to 0, and at that midnight the day of week goes from 7 to 1 (otherwise it adds 1). With no tick and no calendar write, both calendar words stay unchanged.
- R5: At midnight the day wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days; the other months have 31, except month 2. Month 2 has 29 days in a leap year (divisible by 4 and not by 100, or divisible by 400) and 28 otherwise. When the day wraps, the month wraps from 12 to 1 and, on that wrap, the year adds 1.
- R6: Time word bits 22:20 always read as (day + 6) / 7 (integer division) of the current day. Bits 22:20 of a time-word write are ignored.
- R7: The time word places the second in bits 5:0, the minute in 11:6, the hour in 16:12 and the day of week in 19:17. The date word places the day in bits 4:0, the month in 8:5 and the year in 20:9. All other bits read 0.
- R8: Status bits 0, 1 and 4 are event flags. Writing 1 to a flag clears it; writing 0 leaves it unchanged. Bits 2, 3 and 5 are enables that keep the value written. If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: Every seconds tick sets status bit 1.
- R10: Status bit 4 sets on a seconds tick after which both calendar words equal both alarm words (week of month included). A calendar write that makes the words equal does not set it.
- R11: Status bit 0 sets on a seconds tick after which the hour, minute and second equal bits 16:0 of the alarm time word, whatever the date.
- R12: `irq` is high exactly when status shows (bit 0 and bit 2), (bit 1 and bit 3), or (bit 4 and bit 5).
- R13: `req_ready` is always 1. A read accepted in one cycle returns, in the next cycle, `rsp_valid` high with the register value as it stood before that edge. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle pulse per reference tick |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, any enabled latched event |

## Verification
A fault in the calendar carry chain shows up only when the affected field rolls over. The bench therefore sets the calendar just before each kind of boundary: minute, midnight, every month length, both century leap cases and year end. It then reads the words back within a few cycles of the tick. A divider or flag fault shows first on `irq`, which the reference model compares on every clock. That makes a missed or early seconds tick visible in the same cycle it happens. A wrong alarm compare point, such as comparing before the update or against newly written alarm words, surfaces at the tick where the alarm should or should not fire.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int DIV_W   = 16;
  localparam int YEAR_W  = 12;
  localparam int STAT_W  = 6;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_TIME  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATE  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ATIME = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ADATE = 8'h1C;

  // status bit positions
  localparam int ST_DAILY   = 0;
  localparam int ST_SEC     = 1;
  localparam int ST_DAILYEN = 2;
  localparam int ST_SECEN   = 3;
  localparam int ST_FULL    = 4;
  localparam int ST_FULLEN  = 5;
  localparam logic [STAT_W-1:0] FLAG_MASK = 6'b010011;

  typedef struct packed {
    logic [2:0] dow;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [3:0]        month;
    logic [4:0]        day;
  } cal_date_t;

  localparam int TIME_W  = $bits(cal_time_t);
  localparam int DATE_W  = $bits(cal_date_t);
  localparam int ATIME_W = TIME_W + 3;

  function automatic logic [2:0] week_of(input logic [4:0] day);
    logic [5:0] s;
    s = {1'b0, day} + 6'd6;
    return 3'(s / 6'd7);
  endfunction

  function automatic logic is_leap(input logic [YEAR_W-1:0] y);
    return (y[1:0] == 2'b00) &&
           (((y % YEAR_W'(100)) != '0) || ((y % YEAR_W'(400)) == '0));
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [YEAR_W-1:0] y);
    case (m)
      4'd2:                   return is_leap(y) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider import rtc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             sec_tick,
  output logic [DIV_W-1:0] count
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q >= divisor);
  assign sec_tick = tick_in && !restart && at_end;
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick_in) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; #(
  parameter logic [YEAR_W-1:0] YEAR_RESET = 12'd2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        time_wr,
  input  logic        date_wr,
  input  logic [31:0] wdata,
  output cal_time_t   time_q,
  output cal_date_t   date_q,
  output cal_time_t   time_nx,
  output cal_date_t   date_nx
);
  cal_time_t adv_t;
  cal_date_t adv_d;
  logic sec_wrap, min_wrap, hr_wrap, midnight, day_end, year_end;

  always_comb begin
    sec_wrap = time_q.sec  >= 6'd59;
    min_wrap = time_q.min  >= 6'd59;
    hr_wrap  = time_q.hour >= 5'd23;
    midnight = sec_wrap && min_wrap && hr_wrap;
    day_end  = date_q.day >= month_len(date_q.month, date_q.year);
    year_end = date_q.month >= 4'd12;

    adv_t = time_q;
    adv_d = date_q;
    adv_t.sec = sec_wrap ? 6'd0 : time_q.sec + 6'd1;
    if (sec_wrap)
      adv_t.min = min_wrap ? 6'd0 : time_q.min + 6'd1;
    if (sec_wrap && min_wrap)
      adv_t.hour = hr_wrap ? 5'd0 : time_q.hour + 5'd1;
    if (midnight) begin
      adv_t.dow = (time_q.dow >= 3'd7) ? 3'd1 : time_q.dow + 3'd1;
      adv_d.day = day_end ? 5'd1 : date_q.day + 5'd1;
    end
    if (midnight && day_end)
      adv_d.month = year_end ? 4'd1 : date_q.month + 4'd1;
    if (midnight && day_end && year_end)
      adv_d.year = date_q.year + 1'b1;
  end

  always_comb begin
    if (time_wr)       time_nx = cal_time_t'(wdata[TIME_W-1:0]);
    else if (sec_tick) time_nx = adv_t;
    else               time_nx = time_q;
    if (date_wr)       date_nx = cal_date_t'(wdata[DATE_W-1:0]);
    else if (sec_tick) date_nx = adv_d;
    else               date_nx = date_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '{dow: 3'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};
      date_q <= '{year: YEAR_RESET, month: 4'd1, day: 5'd1};
    end else begin
      time_q <= time_nx;
      date_q <= date_nx;
    end
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status import rtc_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  cal_time_t          time_nx,
  input  cal_date_t          date_nx,
  input  logic [ATIME_W-1:0] alarm_time,
  input  logic [DATE_W-1:0]  alarm_date,
  input  logic               stat_wr,
  input  logic [STAT_W-1:0]  wdata,
  output logic [STAT_W-1:0]  stat,
  output logic               irq
);
  logic [STAT_W-1:0] stat_q, set_v, stat_d;
  logic match_daily, match_full;

  always_comb begin
    match_daily = {time_nx.hour, time_nx.min, time_nx.sec} == alarm_time[16:0];
    match_full  = ({week_of(date_nx.day), time_nx} == alarm_time) &&
                  (date_nx == cal_date_t'(alarm_date));
    set_v = '0;
    set_v[ST_DAILY] = sec_tick && match_daily;
    set_v[ST_SEC]   = sec_tick;
    set_v[ST_FULL]  = sec_tick && match_full;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_flag
      assign stat_d[i] = set_v[i] | (stat_q[i] & ~(stat_wr & wdata[i]));
    end else begin : g_en
      assign stat_d[i] = stat_wr ? wdata[i] : stat_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = (stat_q[ST_DAILY] & stat_q[ST_DAILYEN]) |
                (stat_q[ST_SEC]   & stat_q[ST_SECEN])   |
                (stat_q[ST_FULL]  & stat_q[ST_FULLEN]);
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
  parameter logic [DIV_W-1:0]  DIV_RESET  = 16'd32767,
  parameter logic [DIV_W-1:0]  TRIM_RESET = 16'd0,
  parameter logic [YEAR_W-1:0] YEAR_RESET = 12'd2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic [DIV_W-1:0]   div_q, trim_q, div_count;
  logic [ATIME_W-1:0] atime_q;
  logic [DATE_W-1:0]  adate_q;
  logic [STAT_W-1:0]  stat;
  logic               wr, rd, time_wr, date_wr, cal_wr, sec_tick;
  cal_time_t          time_q, time_nx;
  cal_date_t          date_q, date_nx;
  logic [DATA_W-1:0]  rd_mux;

  assign req_ready = 1'b1;
  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign time_wr = wr && (req_addr == OFS_TIME);
  assign date_wr = wr && (req_addr == OFS_DATE);
  assign cal_wr  = time_wr || date_wr;

  rtc_divider u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_32k), .restart(cal_wr),
    .divisor(div_q), .sec_tick(sec_tick), .count(div_count)
  );

  rtc_calendar #(.YEAR_RESET(YEAR_RESET)) u_cal (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_wr(time_wr),
    .date_wr(date_wr), .wdata(req_wdata), .time_q(time_q), .date_q(date_q),
    .time_nx(time_nx), .date_nx(date_nx)
  );

  rtc_status u_stat (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_nx(time_nx),
    .date_nx(date_nx), .alarm_time(atime_q), .alarm_date(adate_q),
    .stat_wr(wr && (req_addr == OFS_STAT)), .wdata(req_wdata[STAT_W-1:0]),
    .stat(stat), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_RESET;
      trim_q  <= TRIM_RESET;
      atime_q <= '0;
      adate_q <= '0;
    end else if (wr) begin
      case (req_addr)
        OFS_DIV:   {trim_q, div_q} <= req_wdata;
        OFS_ATIME: atime_q <= req_wdata[ATIME_W-1:0];
        OFS_ADATE: adate_q <= req_wdata[DATE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      OFS_STAT:  rd_mux = DATA_W'(stat);
      OFS_DIV:   rd_mux = {trim_q, div_q};
      OFS_TIME:  rd_mux = DATA_W'({week_of(date_q.day), time_q});
      OFS_DATE:  rd_mux = DATA_W'(date_q);
      OFS_ATIME: rd_mux = DATA_W'(atime_q);
      OFS_ADATE: rd_mux = DATA_W'(adate_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk import rtc_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             cal_wr,
  input logic [DIV_W-1:0] div_count,
  input cal_time_t        time_q,
  input cal_date_t        date_q,
  input logic [STAT_W-1:0] stat
);
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr |=> (div_count == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !cal_wr) |=> ($stable(time_q) && $stable(date_q)));

  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && time_q.sec < 6'd59) |=> (time_q.sec == $past(time_q.sec) + 6'd1));

  p_tick_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> stat[ST_SEC]);

  p_full_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_FULL]) |-> $past(sec_tick));

  p_daily_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_DAILY]) |-> $past(sec_tick));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cal_wr(cal_wr),
  .div_count(div_count), .time_q(time_q), .date_q(date_q), .stat(stat)
);

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rtc_core u_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  // reference model state
  int m_sec = 0, m_min = 0, m_hour = 0, m_dow = 1, m_day = 1, m_mon = 1, m_year = 2000;
  int m_cnt = 0, m_div = 32767, m_trim = 0;
  int m_at = 0, m_ad = 0;
  bit m_fa = 0, m_fs = 0, m_ff = 0, m_ea = 0, m_es = 0, m_ef = 0;
  bit e_rv = 0, e_irq = 0;
  logic [31:0] e_rd = '0;

  function automatic int dim(input int mo, input int y);
    bit leap;
    leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] mk_time(input int wom, input int dow, input int h, input int mi, input int s);
    return 32'((wom << 20) | (dow << 17) | (h << 12) | (mi << 6) | s);
  endfunction

  function automatic logic [31:0] mk_date(input int y, input int mo, input int d);
    return 32'((y << 9) | (mo << 5) | d);
  endfunction

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    case (a)
      8'h08: return {26'd0, m_ef, m_ff, m_es, m_ea, m_fs, m_fa};
      8'h0C: return 32'((m_trim << 16) | m_div);
      8'h10: return mk_time((m_day + 6) / 7, m_dow, m_hour, m_min, m_sec);
      8'h14: return mk_date(m_year, m_mon, m_day);
      8'h18: return 32'(m_at);
      8'h1C: return 32'(m_ad);
      default: return 32'd0;
    endcase
  endfunction

  task automatic advance();
    m_sec++;
    if (m_sec >= 60) begin
      m_sec = 0; m_min++;
      if (m_min >= 60) begin
        m_min = 0; m_hour++;
        if (m_hour >= 24) begin
          m_hour = 0;
          m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
          m_day++;
          if (m_day > dim(m_mon, m_year)) begin
            m_day = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 4096; end
          end
        end
      end
    end
  endtask

  task automatic model_step(input logic t, input logic v, input logic w, input logic [7:0] a, input logic [31:0] d);
    bit tick, calw, sw, mfull, mdaily;
    e_rv = v && !w;
    e_rd = e_rv ? mdl_read(a) : 32'd0;
    calw = v && w && (a == 8'h10 || a == 8'h14);
    sw   = v && w && (a == 8'h08);
    tick = 0;
    if (calw) m_cnt = 0;
    else if (t) begin
      if (m_cnt >= m_div) begin m_cnt = 0; tick = 1; end
      else m_cnt++;
    end
    if (tick) advance();
    mfull  = (mdl_read(8'h10) == 32'(m_at)) && (mdl_read(8'h14) == 32'(m_ad));
    mdaily = (((m_hour << 12) | (m_min << 6) | m_sec) == (m_at & 32'h1FFFF));
    m_fa = (tick && mdaily) || (m_fa && !(sw && d[0]));
    m_fs = tick || (m_fs && !(sw && d[1]));
    m_ff = (tick && mfull) || (m_ff && !(sw && d[4]));
    if (sw) begin m_ea = d[2]; m_es = d[3]; m_ef = d[5]; end
    if (v && w) begin
      case (a)
        8'h0C: begin m_div = int'(d[15:0]); m_trim = int'(d[31:16]); end
        8'h10: begin m_sec = int'(d[5:0]); m_min = int'(d[11:6]); m_hour = int'(d[16:12]); m_dow = int'(d[19:17]); end
        8'h14: begin m_day = int'(d[4:0]); m_mon = int'(d[8:5]); m_year = int'(d[20:9]); end
        8'h18: m_at = int'(d[22:0]);
        8'h1C: m_ad = int'(d[20:0]);
        default: ;
      endcase
    end
    e_irq = (m_fa && m_ea) || (m_fs && m_es) || (m_ff && m_ef);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t, input logic v, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    tick_32k = t; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    model_step(t, v, w, a, d);
    @(posedge clk); #1;
    check("R12 irq", {31'd0, irq}, {31'd0, e_irq});
    check("R13 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
    check("R13 req_ready", {31'd0, req_ready}, 32'd1);
    if (e_rv) check(tag, rsp_rdata, e_rd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1'b0, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1'b0, 1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic run(input int n, input logic t);
    for (int i = 0; i < n; i++) cyc(t, 1'b0, 1'b0, 8'h00, 32'd0, "R12");
  endtask
  task automatic set_cal(input int y, input int mo, input int d, input int dow, input int h, input int mi, input int s);
    wr(8'h14, mk_date(y, mo, d), "R3");
    wr(8'h10, mk_time(0, dow, h, mi, s), "R3");
  endtask
  task automatic show(input string tag);
    rd(8'h10, tag);
    rd(8'h14, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1");
    rd(8'h14, "R1"); rd(8'h18, "R1"); rd(8'h1C, "R1");
    // R2 default divider, with seconds-event interrupt enabled
    wr(8'h08, 32'h08, "R8");
    run(32767, 1'b1);
    rd(8'h08, "R2");
    rd(8'h10, "R2");
    run(1, 1'b1);
    rd(8'h08, "R9");
    rd(8'h10, "R2");
    wr(8'h08, 32'h02, "R8");
    // R2 small divisor with trim
    wr(8'h0C, 32'h0005_0003, "R2");
    rd(8'h0C, "R2");
    run(9, 1'b1);
    rd(8'h10, "R2");
    // R3 restart and dropped tick; R7 layout
    set_cal(2024, 2, 28, 7, 23, 59, 58);
    show("R7");
    run(3, 1'b1);
    rd(8'h10, "R3");
    cyc(1'b1, 1'b1, 1'b1, 8'h10, mk_time(0, 7, 23, 59, 58), "R3");
    run(3, 1'b1);
    rd(8'h10, "R3");
    run(1, 1'b1);
    rd(8'h10, "R4");
    run(4, 1'b1);
    show("R5 leap 2024");
    rd(8'h10, "R6");
    // century rules
    set_cal(2100, 2, 28, 3, 23, 59, 59); run(4, 1'b1); show("R5 2100");
    set_cal(2000, 2, 28, 3, 23, 59, 59); run(4, 1'b1); show("R5 2000");
    set_cal(2000, 2, 29, 3, 23, 59, 59); run(4, 1'b1); show("R5 2000 end");
    set_cal(2023, 12, 31, 6, 23, 59, 59); run(4, 1'b1); show("R5 year");
    set_cal(2023, 4, 30, 2, 23, 59, 59); run(4, 1'b1); show("R5 30-day");
    set_cal(2023, 5, 31, 2, 23, 59, 59); run(4, 1'b1); show("R5 31-day");
    set_cal(2023, 5, 10, 2, 10, 59, 59); run(4, 1'b1); show("R4 hour carry");
    // R6 written week bits ignored
    wr(8'h14, mk_date(2023, 5, 8), "R6");
    wr(8'h10, mk_time(7, 3, 1, 2, 3), "R6");
    rd(8'h10, "R6");
    wr(8'h14, mk_date(2023, 5, 29), "R6");
    rd(8'h10, "R6");
    // R8 flags and enables
    wr(8'h08, 32'h3F, "R8"); rd(8'h08, "R8");
    run(8, 1'b1);
    wr(8'h08, 32'h2C, "R8"); rd(8'h08, "R8");
    wr(8'h08, 32'h2E, "R8"); rd(8'h08, "R8");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 8'h08, 32'h2E, "R8");
    rd(8'h08, "R8");
    wr(8'h08, 32'h00, "R8"); rd(8'h08, "R8");
    // R10 full alarm
    set_cal(2030, 6, 15, 2, 8, 0, 0);
    wr(8'h18, mk_time(3, 2, 8, 0, 2), "R10");
    wr(8'h1C, mk_date(2030, 6, 15), "R10");
    wr(8'h08, 32'h20, "R10");
    run(4, 1'b1); rd(8'h08, "R10");
    run(4, 1'b1); rd(8'h08, "R10");
    wr(8'h08, 32'h33, "R10");
    wr(8'h10, mk_time(0, 2, 8, 0, 2), "R10");
    run(2, 1'b0); rd(8'h08, "R10");
    // R11 daily alarm on another date
    wr(8'h1C, mk_date(2031, 1, 1), "R11");
    wr(8'h18, mk_time(0, 1, 8, 0, 5), "R11");
    wr(8'h08, 32'h04, "R11");
    wr(8'h10, mk_time(0, 2, 8, 0, 4), "R11");
    run(4, 1'b1); rd(8'h08, "R11");
    wr(8'h08, 32'h01, "R11"); rd(8'h08, "R11");
    // R13 unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF, "R13"); wr(8'h00, 32'hFFFF_FFFF, "R13");
    rd(8'h20, "R13"); rd(8'h00, "R13");
    rd(8'h08, "R13"); rd(8'h0C, "R13"); rd(8'h18, "R13"); rd(8'h1C, "R13");
    show("R13");
    run(2, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule